// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps the outcome of finished transmissions until the host has read them. The transmit engine reports each finished packet with a one-cycle `mac_done` pulse. The pulse carries flags for an interrupt request on success, jabber, underrun and excessive collisions. Results worth reporting are pushed onto a shallow last-in, first-out store. The host reads the most recent result as an 8-bit status byte and removes it by writing to that register, signalled here by `host_wr`.

While any result is held, the block drives a transmit-complete interrupt cause. It marks results that were lost to a full store with an overflow bit. Jabber and underrun halt the transmitter, and so does a transmit FIFO overrun, which also signals an adapter failure. Both conditions stay set until a transmit reset or a global reset. The transmit engine, its FIFO and collision handling are outside the block.

Top module: `tx_cmpl_stack`

## Requirements
- R1: Status byte layout: bit 7 = completed, bit 6 = interrupt on success requested, bit 5 = jabber, bit 4 = underrun, bit 3 = excessive collisions, bit 2 = entries lost (overflow). Bits 1:0 always read 0, and bit 7 is 1 whenever an entry is shown.
- R2: A qualifying `mac_done` pulse makes its entry the top entry, shown on `tx_status` from the next clock edge on. The most recently pushed entry is always the one shown.
- R3: A `mac_done` with no error flag and no interrupt request is not stored. A `mac_done` with any of jabber, underrun or excessive collisions is stored whether or not an interrupt was requested.
- R4: A `host_wr` pulse removes the top entry and exposes the one below it. A `host_wr` while the store is empty has no effect.
- R5: A `host_wr` in the same cycle as a qualifying push replaces the top entry with the new one, and the depth is unchanged.
- R6: The store holds `DEPTH` entries (default 4). A qualifying push while it is full discards the new result and sets bit 2 of the entry then on top.
- R7: `tx_cmpl_irq` is 1 exactly while the store holds an entry. When it is empty, `tx_status` reads 8'h00.
- R8: A completion with jabber or underrun sets `tx_halted`. It stays set through any other traffic until `tx_reset`.
- R9: An `fifo_overrun` pulse sets both `tx_halted` and `adapter_fail`. They stay set until `tx_reset` or a global reset.
- R10: `tx_reset` empties the store and clears `tx_halted` and `adapter_fail`. It takes priority over a push, pop or fault in the same cycle.
- R11: After global reset, `tx_status` is 0 and `tx_cmpl_irq`, `tx_halted` and `adapter_fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, asserted asynchronously |
| mac_done | input | 1 | One-cycle pulse: a transmission finished |
| mac_irq_req | input | 1 | Interrupt requested on successful completion |
| mac_jabber | input | 1 | Transmission ended in jabber |
| mac_underrun | input | 1 | Transmission ended in underrun |
| mac_max_coll | input | 1 | Transmission gave up after maximum collisions |
| fifo_overrun | input | 1 | One-cycle pulse: transmit FIFO was overrun |
| host_wr | input | 1 | Host write to the status register; pops the top entry |
| tx_reset | input | 1 | One-cycle transmit reset command |
| tx_status | output | 8 | Top status entry, or 0 when empty |
| tx_cmpl_irq | output | 1 | Transmit-complete interrupt cause |
| tx_halted | output | 1 | Transmitter disabled pending a transmit reset |
| adapter_fail | output | 1 | Adapter failure caused by a FIFO overrun |

## Verification
Each result has one register stage. A push, pop, fault or transmit reset presented in one clock cycle shows on `tx_status`, `tx_cmpl_irq`, `tx_halted` and `adapter_fail` right after the next rising edge. A global reset release takes effect only after its two-stage synchronizer, so the bench waits three edges before driving anything. The bench applies each stimulus on a falling edge and removes it on the next falling edge. It samples the outputs at that second falling edge, half a period after the edge that updated them. The sticky checks let several idle cycles pass before sampling, to show that the state holds.

// File: rtl/tx_cmpl_pkg.sv
package tx_cmpl_pkg;

  // One stored completion result; packing order equals status bits 7..2
  typedef struct packed {
    logic done;
    logic irq_req;
    logic jabber;
    logic underrun;
    logic max_coll;
    logic lost;
  } txc_entry_t;

  localparam int unsigned ENTRY_W  = $bits(txc_entry_t);
  localparam int unsigned STATUS_W = 8;
  localparam int unsigned PAD_W    = STATUS_W - ENTRY_W;

  function automatic logic [STATUS_W-1:0] entry_to_status(input txc_entry_t e);
    return {e, {PAD_W{1'b0}}};
  endfunction

endpackage

// File: rtl/txc_entry_fmt.sv
module txc_entry_fmt
  import tx_cmpl_pkg::*;
(
  input  logic       done,
  input  logic       irq_req,
  input  logic       jabber,
  input  logic       underrun,
  input  logic       max_coll,
  output logic       store,
  output logic       halt_evt,
  output txc_entry_t entry
);

  logic any_err;

  always_comb begin
    any_err        = jabber | underrun | max_coll;
    store          = done & (any_err | irq_req);
    halt_evt       = done & (jabber | underrun);
    entry.done     = 1'b1;
    entry.irq_req  = irq_req;
    entry.jabber   = jabber;
    entry.underrun = underrun;
    entry.max_coll = max_coll;
    entry.lost     = 1'b0;
  end

endmodule

// File: rtl/txc_lifo.sv
module txc_lifo
  import tx_cmpl_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  txc_entry_t push_entry,
  input  logic       pop,
  output txc_entry_t top_entry,
  output logic       not_empty
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]        cnt_q, cnt_d;
  txc_entry_t [DEPTH-1:0]  slot_q;
  logic                    is_empty, is_full, do_pop;
  logic [IDX_W-1:0]        top_idx;
  logic                    wr_en;
  logic [IDX_W-1:0]        wr_idx;
  txc_entry_t              wr_data;

  always_comb begin
    is_empty = (cnt_q == '0);
    is_full  = (cnt_q == CNT_FULL);
    do_pop   = pop & ~is_empty;
    top_idx  = is_empty ? '0 : IDX_W'(cnt_q - CNT_ONE);
  end

  // Next-state: store pointer and the single slot write of this cycle
  always_comb begin
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    wr_idx  = top_idx;
    wr_data = push_entry;
    if (clr) begin
      cnt_d = '0;
    end else if (push && do_pop) begin
      wr_en = 1'b1;
    end else if (push && !is_full) begin
      wr_en  = 1'b1;
      wr_idx = IDX_W'(cnt_q);
      cnt_d  = cnt_q + CNT_ONE;
    end else if (push) begin
      wr_en        = 1'b1;
      wr_data      = slot_q[top_idx];
      wr_data.lost = 1'b1;
    end else if (do_pop) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    txc_entry_t q;
    logic       en;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign slot_q[g] = q;
  end

  assign top_entry = is_empty ? '0 : slot_q[top_idx];
  assign not_empty = ~is_empty;

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push && !pop && !clr) |=> (cnt_q == CNT_FULL) && top_entry.lost);
  p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_empty && pop && !push && !clr) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
  p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_empty && pop && push && !clr) |=>
      (cnt_q == $past(cnt_q)) && (top_entry == $past(push_entry)));
  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !not_empty);

endmodule

// File: rtl/txc_fault_lock.sv
module txc_fault_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_reset,
  input  logic halt_evt,
  input  logic fifo_overrun,
  output logic halted,
  output logic failed
);

  logic halt_q, halt_d, fail_q, fail_d;

  always_comb begin
    halt_d = halt_q;
    fail_d = fail_q;
    if (tx_reset) begin
      halt_d = 1'b0;
      fail_d = 1'b0;
    end else begin
      if (halt_evt || fifo_overrun) halt_d = 1'b1;
      if (fifo_overrun)             fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      fail_q <= fail_d;
    end
  end

  assign halted = halt_q;
  assign failed = fail_q;

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !tx_reset) |=> halted);
  p_halt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !tx_reset) |=> halted);
  p_fail_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_overrun && !tx_reset) |=> (failed && halted));
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (!halted && !failed));

endmodule

// File: rtl/tx_cmpl_stack.sv
module tx_cmpl_stack
  import tx_cmpl_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mac_done,
  input  logic       mac_irq_req,
  input  logic       mac_jabber,
  input  logic       mac_underrun,
  input  logic       mac_max_coll,
  input  logic       fifo_overrun,
  input  logic       host_wr,
  input  logic       tx_reset,
  output logic [7:0] tx_status,
  output logic       tx_cmpl_irq,
  output logic       tx_halted,
  output logic       adapter_fail
);

  // Reset: asserted asynchronously, released on the second clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic       store, halt_evt, not_empty;
  txc_entry_t new_entry, top_entry;

  txc_entry_fmt u_fmt (
    .done     (mac_done),
    .irq_req  (mac_irq_req),
    .jabber   (mac_jabber),
    .underrun (mac_underrun),
    .max_coll (mac_max_coll),
    .store    (store),
    .halt_evt (halt_evt),
    .entry    (new_entry)
  );

  txc_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr        (tx_reset),
    .push       (store),
    .push_entry (new_entry),
    .pop        (host_wr),
    .top_entry  (top_entry),
    .not_empty  (not_empty)
  );

  txc_fault_lock u_lock (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tx_reset     (tx_reset),
    .halt_evt     (halt_evt),
    .fifo_overrun (fifo_overrun),
    .halted       (tx_halted),
    .failed       (adapter_fail)
  );

  assign tx_status   = entry_to_status(top_entry);
  assign tx_cmpl_irq = not_empty;

  p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_cmpl_irq |-> (tx_status == 8'h00));
  p_layout_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_cmpl_irq |-> (tx_status[7] && (tx_status[1:0] == 2'b00)));
  p_filter_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tx_cmpl_irq && mac_done && !mac_irq_req && !mac_jabber && !mac_underrun
      && !mac_max_coll && !tx_reset) |=> !tx_cmpl_irq);

endmodule

// File: tb/tx_cmpl_stack_tb.sv
module tx_cmpl_stack_tb;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mac_done = 0, mac_irq_req = 0, mac_jabber = 0, mac_underrun = 0;
  logic       mac_max_coll = 0, fifo_overrun = 0, host_wr = 0, tx_reset = 0;
  logic [7:0] tx_status;
  logic       tx_cmpl_irq, tx_halted, adapter_fail;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_cmpl_stack #(.DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mac_done(mac_done), .mac_irq_req(mac_irq_req), .mac_jabber(mac_jabber),
    .mac_underrun(mac_underrun), .mac_max_coll(mac_max_coll),
    .fifo_overrun(fifo_overrun), .host_wr(host_wr), .tx_reset(tx_reset),
    .tx_status(tx_status), .tx_cmpl_irq(tx_cmpl_irq),
    .tx_halted(tx_halted), .adapter_fail(adapter_fail)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Drive one cycle of inputs from a falling edge to the next falling edge
  task automatic step(input logic d, ir, jb, un, mc, wr, ov, tr);
    mac_done = d; mac_irq_req = ir; mac_jabber = jb; mac_underrun = un;
    mac_max_coll = mc; host_wr = wr; fifo_overrun = ov; tx_reset = tr;
    @(negedge clk);
    mac_done = 0; mac_irq_req = 0; mac_jabber = 0; mac_underrun = 0;
    mac_max_coll = 0; host_wr = 0; fifo_overrun = 0; tx_reset = 0;
  endtask

  task automatic push(input logic ir, jb, un, mc);
    step(1'b1, ir, jb, un, mc, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic pop();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask
  task automatic treset();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic global_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset_state();
    chk("R11 status", tx_status, 8'h00);
    chk("R11 irq", {7'd0, tx_cmpl_irq}, 8'h01 & 8'h00);
    chk("R11 halted", {7'd0, tx_halted}, 8'h00);
    chk("R11 fail", {7'd0, adapter_fail}, 8'h00);
  endtask

  task automatic t_layout();
    push(1, 0, 0, 1);
    chk("R1 R2 irq_req+maxcoll byte", tx_status, 8'hC8);
    chk("R7 irq while held", {7'd0, tx_cmpl_irq}, 8'h01);
    pop();
    chk("R4 pop to empty", tx_status, 8'h00);
    chk("R7 irq empty", {7'd0, tx_cmpl_irq}, 8'h00);
  endtask

  task automatic t_filter();
    push(0, 0, 0, 0);
    chk("R3 quiet success dropped", tx_status, 8'h00);
    chk("R3 quiet success no irq", {7'd0, tx_cmpl_irq}, 8'h00);
    push(0, 0, 0, 1);
    chk("R3 error kept without irq_req", tx_status, 8'h88);
    pop();
  endtask

  task automatic t_order();
    push(1, 0, 0, 0);
    push(0, 0, 0, 1);
    chk("R2 newest on top", tx_status, 8'h88);
    pop();
    chk("R4 older exposed", tx_status, 8'hC0);
    pop();
    chk("R4 empty after two pops", tx_status, 8'h00);
    pop();
    chk("R4 pop on empty status", tx_status, 8'h00);
    chk("R4 pop on empty irq", {7'd0, tx_cmpl_irq}, 8'h00);
    push(1, 0, 0, 0);
    chk("R4 store usable after empty pop", tx_status, 8'hC0);
    pop();
  endtask

  task automatic t_swap();
    push(1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 1, 0, 0);
    chk("R5 top replaced", tx_status, 8'h88);
    pop();
    chk("R5 depth unchanged", tx_status, 8'h00);
  endtask

  task automatic t_overflow();
    push(1, 0, 0, 0);
    push(1, 0, 0, 0);
    push(1, 0, 0, 0);
    push(0, 0, 0, 1);
    chk("R6 full top", tx_status, 8'h88);
    push(1, 0, 0, 1);
    chk("R6 dropped push marks lost", tx_status, 8'h8C);
    pop();
    chk("R6 lower entry unmarked", tx_status, 8'hC0);
    pop();
    pop();
    chk("R6 last entry", tx_status, 8'hC0);
    pop();
    chk("R6 drained", tx_status, 8'h00);
  endtask

  task automatic t_lock();
    push(0, 1, 0, 0);
    chk("R8 jabber byte", tx_status, 8'hA0);
    chk("R8 halted on jabber", {7'd0, tx_halted}, 8'h01);
    pop();
    push(1, 0, 0, 0);
    idle(4);
    chk("R8 halt holds", {7'd0, tx_halted}, 8'h01);
    treset();
    chk("R10 store emptied", tx_status, 8'h00);
    chk("R10 irq cleared", {7'd0, tx_cmpl_irq}, 8'h00);
    chk("R10 halt cleared", {7'd0, tx_halted}, 8'h00);
    push(0, 0, 1, 0);
    chk("R8 underrun byte", tx_status, 8'h90);
    chk("R8 halted on underrun", {7'd0, tx_halted}, 8'h01);
    treset();
    chk("R10 halt cleared again", {7'd0, tx_halted}, 8'h00);
  endtask

  task automatic t_fifo();
    step(0, 0, 0, 0, 0, 0, 1, 0);
    idle(3);
    chk("R9 fail set", {7'd0, adapter_fail}, 8'h01);
    chk("R9 halt set", {7'd0, tx_halted}, 8'h01);
    chk("R9 no status entry", tx_status, 8'h00);
    treset();
    chk("R9 fail cleared by tx_reset", {7'd0, adapter_fail}, 8'h00);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    push(1, 0, 0, 0);
    global_reset();
    chk("R9 fail cleared by global reset", {7'd0, adapter_fail}, 8'h00);
    chk("R9 halt cleared by global reset", {7'd0, tx_halted}, 8'h00);
    chk("R11 store cleared by global reset", tx_status, 8'h00);
  endtask

  task automatic t_reset_priority();
    push(1, 0, 0, 0);
    step(1, 0, 1, 0, 0, 1, 1, 1);
    chk("R10 reset beats push", tx_status, 8'h00);
    chk("R10 reset beats fault halt", {7'd0, tx_halted}, 8'h00);
    chk("R10 reset beats fault fail", {7'd0, adapter_fail}, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    global_reset();
    t_reset_state();
    t_layout();
    t_filter();
    t_order();
    t_swap();
    t_overflow();
    t_lock();
    t_fifo();
    t_reset_priority();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule